// File: doc/BRIEF.md
# USB Endpoint Control with DMA Gating

This block is the per-endpoint control section of a USB device controller. Software changes its control bits only through a pair of strobe vectors. Each bit has one strobe that sets it and one that clears it, so no read-modify-write is needed. From these bits and from a few hardware events, the block keeps the data toggle for the next packet and the active ping-pong bank. It also keeps a STALL handshake request and a gate on the endpoint's DMA request.

The DMA gate is the core of the block. While the pause-on-interrupt bit is set, any endpoint interrupt closes the gate, whether or not that interrupt is enabled. The bench still checks that the gate ignores interrupts while the pause bit is clear. An event tied to a freshly filled bank lets the transfer already in flight on the older bank run to its end, and only then holds the request low. Any other event, such as a NAK, closes the gate at once. The gate reopens when the interrupt source is acknowledged or disabled, or when software clears the pause bit.

There is no data stream through this block, so every pin is a plain level or single-cycle pulse. No valid/ready handshake is involved. The DMA engine raises `dma_want` when it has work for the endpoint. It holds `dma_active` while a transfer on the current bank is under way.

Top module: `usb_ep_ctl`

## Requirements
- R1: The control readback `ctrl_q` has fields FIFO-hold (bit 0), DMA-pause-on-interrupt (bit 1), toggle-reset (bit 2) and STALL (bit 3). A 1 on `set_stb[i]` sets bit i at the next clock edge. A 1 on `clr_stb[i]` clears it. A 0 on either strobe leaves the bit unchanged.
- R2: When the set strobe and the clear strobe of the same bit are both 1 in one cycle, the bit ends up set.
- R3: While reset is asserted, all of the following hold: `ctrl_q` is 0, `data_tgl` is 0 (DATA0), `cur_bank` is 0, `stall_req` is 0 and `dma_req` is 0.
- R4: With bit 1 set, an `irq_evt` that has `irq_new_bank`=0 drives `dma_req` low from the next cycle on, even while `dma_active` is 1.
- R5: With bit 1 set, an `irq_evt` that has `irq_new_bank`=1 and arrives while `dma_active` is 1 leaves `dma_req` following `dma_want` for as long as `dma_active` stays 1. `dma_req` goes low in the first cycle in which `dma_active` is 0. If `dma_active` is 0 when such an event arrives, `dma_req` goes low from the next cycle.
- R6: A paused request stays low until either `irq_clr` pulses or bit 1 is cleared through its clear strobe. From the next cycle on, `dma_req` follows `dma_want` again. An interrupt event in the same cycle as either of these wins over the resume. `dma_req` is never 1 while `dma_want` is 0.
- R7: With bit 1 clear, `irq_evt` has no effect on `dma_req`.
- R8: Each `pkt_done` pulse inverts `data_tgl` at the next edge.
- R9: A 1 on `set_stb[2]` forces `data_tgl` to 0 at the next edge, taking priority over a `pkt_done` in the same cycle. Bit 2 of `ctrl_q` always reads 0.
- R10: `stall_req` mirrors bit 3. A `setup_rx` pulse clears it at the next edge and overrides a set strobe in the same cycle. The clear strobe also clears it.
- R11: With two banks, a clear strobe on bit 0 that has no set strobe on bit 0 in the same cycle clears bit 0 and switches `cur_bank` to the other bank at the next edge. With a set strobe on bit 0 in the same cycle, the bank stays where it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| set_stb | input | 4 | Per-bit set strobes |
| clr_stb | input | 4 | Per-bit clear strobes |
| irq_evt | input | 1 | Endpoint interrupt event pulse |
| irq_new_bank | input | 1 | Event belongs to a new bank packet |
| irq_clr | input | 1 | Interrupt source acknowledged or disabled |
| setup_rx | input | 1 | SETUP packet received pulse |
| pkt_done | input | 1 | Packet completed successfully |
| dma_want | input | 1 | DMA engine has work for this endpoint |
| dma_active | input | 1 | DMA transfer on current bank in progress |
| dma_req | output | 1 | Gated DMA request |
| data_tgl | output | 1 | Toggle for next packet (0 = DATA0) |
| stall_req | output | 1 | STALL handshake request |
| cur_bank | output | 1 | Active ping-pong bank |
| ctrl_q | output | 4 | Control bit readback |

## Verification
Every strobe and event lands in a register at the next rising edge. So `ctrl_q`, `data_tgl`, `stall_req` and `cur_bank` change one cycle after their stimulus. `dma_req` combines the registered gate state with the live `dma_want` and `dma_active` inputs. As a result it reacts to those two inputs in the same cycle, and to interrupt events one cycle later. The bench drives inputs just after a falling edge. It advances its reference model on the rising edge and compares every output at the following falling edge. That one comparison point lines up both the same-cycle and the one-cycle results.

// File: rtl/usb_ep_ctl_pkg.sv
package usb_ep_ctl_pkg;
  localparam int CTRL_W   = 4;
  localparam int B_FIFO   = 0;
  localparam int B_DPAUSE = 1;
  localparam int B_TRST   = 2;
  localparam int B_STALL  = 3;
  // bits that hold state; toggle-reset is an action and never stored
  localparam logic [CTRL_W-1:0] HELD_MASK = ~(CTRL_W'(1) << B_TRST);

  typedef enum logic [1:0] {
    GATE_OPEN,
    GATE_DRAIN,
    GATE_SHUT
  } gate_e;
endpackage

// File: rtl/usb_ep_ctl_regs.sv
module usb_ep_ctl_regs
  import usb_ep_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] set_stb,
  input  logic [CTRL_W-1:0] clr_stb,
  input  logic              setup_rx,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              fifo_release,
  output logic              tgl_reset,
  output logic              pause_cleared
);
  logic [CTRL_W-1:0] nxt;

  always_comb begin
    for (int i = 0; i < CTRL_W; i++) begin
      if (set_stb[i])      nxt[i] = 1'b1;
      else if (clr_stb[i]) nxt[i] = 1'b0;
      else                 nxt[i] = ctrl_q[i];
    end
    if (setup_rx) nxt[B_STALL] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= nxt & HELD_MASK;
  end

  assign fifo_release  = clr_stb[B_FIFO] & ~set_stb[B_FIFO];
  assign tgl_reset     = set_stb[B_TRST];
  assign pause_cleared = clr_stb[B_DPAUSE] & ~set_stb[B_DPAUSE];
endmodule

// File: rtl/usb_ep_ctl_seq.sv
module usb_ep_ctl_seq #(
  parameter int NUM_BANKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_reset,
  input  logic pkt_done,
  input  logic fifo_release,
  output logic data_tgl,
  output logic cur_bank
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         data_tgl <= 1'b0;
    else if (tgl_reset) data_tgl <= 1'b0;
    else if (pkt_done)  data_tgl <= ~data_tgl;
  end

  generate
    if (NUM_BANKS > 1) begin : g_pingpong
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cur_bank <= 1'b0;
        else if (fifo_release) cur_bank <= ~cur_bank;
      end
    end else begin : g_single
      logic unused_rel;
      assign unused_rel = fifo_release;
      assign cur_bank   = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/usb_ep_ctl_gate.sv
module usb_ep_ctl_gate
  import usb_ep_ctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pause_en,
  input  logic pause_cleared,
  input  logic irq_evt,
  input  logic irq_new_bank,
  input  logic irq_clr,
  input  logic dma_want,
  input  logic dma_active,
  output logic dma_req
);
  gate_e st, st_nxt;

  always_comb begin
    st_nxt = st;
    if (irq_evt && pause_en) begin
      if (irq_new_bank && dma_active && st != GATE_SHUT) st_nxt = GATE_DRAIN;
      else                                              st_nxt = GATE_SHUT;
    end else if (irq_clr || pause_cleared) begin
      st_nxt = GATE_OPEN;
    end else if (st == GATE_DRAIN && !dma_active) begin
      st_nxt = GATE_SHUT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= GATE_OPEN;
    else        st <= st_nxt;
  end

  always_comb begin
    unique case (st)
      GATE_OPEN:  dma_req = dma_want;
      GATE_DRAIN: dma_req = dma_want & dma_active;
      default:    dma_req = 1'b0;
    endcase
    if (!rst_n) dma_req = 1'b0;
  end
endmodule

// File: rtl/usb_ep_ctl.sv
module usb_ep_ctl
  import usb_ep_ctl_pkg::*;
#(
  parameter int NUM_BANKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] set_stb,
  input  logic [CTRL_W-1:0] clr_stb,
  input  logic              irq_evt,
  input  logic              irq_new_bank,
  input  logic              irq_clr,
  input  logic              setup_rx,
  input  logic              pkt_done,
  input  logic              dma_want,
  input  logic              dma_active,
  output logic              dma_req,
  output logic              data_tgl,
  output logic              stall_req,
  output logic              cur_bank,
  output logic [CTRL_W-1:0] ctrl_q
);
  logic fifo_release, tgl_reset, pause_cleared;

  usb_ep_ctl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .set_stb(set_stb), .clr_stb(clr_stb),
    .setup_rx(setup_rx), .ctrl_q(ctrl_q), .fifo_release(fifo_release),
    .tgl_reset(tgl_reset), .pause_cleared(pause_cleared)
  );

  usb_ep_ctl_seq #(.NUM_BANKS(NUM_BANKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .tgl_reset(tgl_reset), .pkt_done(pkt_done),
    .fifo_release(fifo_release), .data_tgl(data_tgl), .cur_bank(cur_bank)
  );

  usb_ep_ctl_gate u_gate (
    .clk(clk), .rst_n(rst_n), .pause_en(ctrl_q[B_DPAUSE]),
    .pause_cleared(pause_cleared), .irq_evt(irq_evt),
    .irq_new_bank(irq_new_bank), .irq_clr(irq_clr), .dma_want(dma_want),
    .dma_active(dma_active), .dma_req(dma_req)
  );

  assign stall_req = ctrl_q[B_STALL];
endmodule

// File: rtl/usb_ep_ctl_chk.sv
module usb_ep_ctl_chk
  import usb_ep_ctl_pkg::*;
#(
  parameter int NUM_BANKS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CTRL_W-1:0] set_stb,
  input logic [CTRL_W-1:0] clr_stb,
  input logic              irq_evt,
  input logic              irq_new_bank,
  input logic              setup_rx,
  input logic              pkt_done,
  input logic              dma_want,
  input logic              dma_active,
  input logic              dma_req,
  input logic              data_tgl,
  input logic              stall_req,
  input logic              cur_bank,
  input logic [CTRL_W-1:0] ctrl_q
);
  p_set_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb[B_DPAUSE] |=> ctrl_q[B_DPAUSE]);

  p_hard_pause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_evt && !irq_new_bank && ctrl_q[B_DPAUSE]) |=> !dma_req);

  p_idle_bank_pause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_evt && irq_new_bank && ctrl_q[B_DPAUSE] && !dma_active) |=> !dma_req);

  p_req_needs_want_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> dma_want);

  p_toggle_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && !set_stb[B_TRST]) |=> data_tgl != $past(data_tgl));

  p_toggle_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb[B_TRST] |=> !data_tgl);

  p_trst_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[B_TRST]);

  p_setup_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    setup_rx |=> !stall_req);

  p_bank_switch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (NUM_BANKS > 1 && clr_stb[B_FIFO] && !set_stb[B_FIFO])
      |=> cur_bank != $past(cur_bank));
endmodule

bind usb_ep_ctl usb_ep_ctl_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .set_stb(set_stb), .clr_stb(clr_stb),
  .irq_evt(irq_evt), .irq_new_bank(irq_new_bank), .setup_rx(setup_rx),
  .pkt_done(pkt_done), .dma_want(dma_want), .dma_active(dma_active),
  .dma_req(dma_req), .data_tgl(data_tgl), .stall_req(stall_req),
  .cur_bank(cur_bank), .ctrl_q(ctrl_q)
);

// File: tb/usb_ep_ctl_bench.sv
module usb_ep_ctl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] set_stb = '0, clr_stb = '0;
  logic irq_evt = 0, irq_new_bank = 0, irq_clr = 0, setup_rx = 0, pkt_done = 0;
  logic dma_want = 0, dma_active = 0;
  logic dma_req, data_tgl, stall_req, cur_bank;
  logic [3:0] ctrl_q;

  int checks = 0, fails = 0, cycles = 0;
  string tag = "R3";

  // reference model state
  bit m_fifo, m_pause, m_stall, m_tgl, m_bank;
  int m_gate; // 0 open, 1 finishing old bank, 2 closed

  always #10 clk = ~clk;

  usb_ep_ctl u_usb_ep_ctl (
    .clk(clk), .rst_n(rst_n), .set_stb(set_stb), .clr_stb(clr_stb),
    .irq_evt(irq_evt), .irq_new_bank(irq_new_bank), .irq_clr(irq_clr),
    .setup_rx(setup_rx), .pkt_done(pkt_done), .dma_want(dma_want),
    .dma_active(dma_active), .dma_req(dma_req), .data_tgl(data_tgl),
    .stall_req(stall_req), .cur_bank(cur_bank), .ctrl_q(ctrl_q)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_fifo <= 0; m_pause <= 0; m_stall <= 0; m_tgl <= 0; m_bank <= 0; m_gate <= 0;
    end else begin
      if (set_stb[0]) m_fifo <= 1;
      else if (clr_stb[0]) begin m_fifo <= 0; m_bank <= !m_bank; end
      if (set_stb[1]) m_pause <= 1; else if (clr_stb[1]) m_pause <= 0;
      if (setup_rx) m_stall <= 0;
      else if (set_stb[3]) m_stall <= 1;
      else if (clr_stb[3]) m_stall <= 0;
      if (set_stb[2]) m_tgl <= 0; else if (pkt_done) m_tgl <= !m_tgl;
      if (irq_evt && m_pause)
        m_gate <= (irq_new_bank && dma_active && m_gate != 2) ? 1 : 2;
      else if (irq_clr || (clr_stb[1] && !set_stb[1])) m_gate <= 0;
      else if (m_gate == 1 && !dma_active) m_gate <= 2;
    end
  end

  task automatic chk1(string what, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    bit exp_req;
    @(negedge clk);
    if (!rst_n) exp_req = 0;
    else if (m_gate == 0) exp_req = dma_want;
    else if (m_gate == 1) exp_req = dma_want && dma_active;
    else exp_req = 0;
    chk1("ctrl_q", ctrl_q, {m_stall, 1'b0, m_pause, m_fifo});
    chk1("dma_req", {3'b0, dma_req}, {3'b0, exp_req});
    chk1("data_tgl", {3'b0, data_tgl}, {3'b0, m_tgl});
    chk1("stall_req", {3'b0, stall_req}, {3'b0, m_stall});
    chk1("cur_bank", {3'b0, cur_bank}, {3'b0, m_bank});
    set_stb = '0; clr_stb = '0; irq_evt = 0; irq_new_bank = 0;
    irq_clr = 0; setup_rx = 0; pkt_done = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    tag = "R3"; dma_want = 1;
    repeat (3) tick();
    rst_n = 1; tick();
    tag = "R1"; set_stb = 4'b0010; tick(); tick();
    set_stb = 4'b0000; clr_stb = 4'b0000; tick();
    clr_stb = 4'b0010; tick(); tick();
    tag = "R2"; set_stb = 4'b1000; clr_stb = 4'b1000; tick(); tick();
    tag = "R10"; setup_rx = 1; tick(); tick();
    set_stb = 4'b1000; setup_rx = 1; tick(); tick();
    set_stb = 4'b1000; tick(); clr_stb = 4'b1000; tick(); tick();
    tag = "R8"; for (int i = 0; i < 3; i++) begin pkt_done = 1; tick(); end
    tick();
    tag = "R9"; pkt_done = 1; set_stb = 4'b0100; tick(); tick();
    pkt_done = 1; tick(); set_stb = 4'b0100; tick(); tick();
    tag = "R11"; set_stb = 4'b0001; tick(); clr_stb = 4'b0001; tick(); tick();
    clr_stb = 4'b0001; tick();
    set_stb = 4'b0001; clr_stb = 4'b0001; tick(); tick();
    tag = "R7"; dma_active = 1; irq_evt = 1; tick(); irq_evt = 1; irq_new_bank = 1; tick(); tick();
    tag = "R4"; set_stb = 4'b0010; tick(); irq_evt = 1; tick(); tick(); tick();
    tag = "R6"; irq_clr = 1; tick(); tick();
    tag = "R5"; irq_evt = 1; irq_new_bank = 1; tick(); tick(); tick();
    dma_want = 0; tick(); dma_want = 1; tick();
    dma_active = 0; tick(); tick(); dma_active = 1; tick();
    tag = "R6"; clr_stb = 4'b0010; tick(); tick();
    tag = "R5"; set_stb = 4'b0010; tick(); dma_active = 0; irq_evt = 1; irq_new_bank = 1; tick(); tick();
    tag = "R6"; irq_clr = 1; irq_evt = 1; tick(); tick(); irq_clr = 1; tick(); tick();
    dma_want = 0; tick(); tick();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule